// File: doc/BRIEF.md
# Block-Write Memory Prefetcher with Ping-Pong Output Buffers

This block handles the memory side of a block-write transfer. It holds an active word address and a bank number, both loaded together by a load strobe. It then fetches words from memory through a port controller, using a two-phase handshake. A read request carries the bank as the target. The port answers with a select, and in that cycle the block drives the word address and advances it by one. A later strobe from the port carries the data word, which the block captures.

Each captured word goes into one of two output buffers, A and B. The block keeps issuing requests while a buffer is free, so both stay filled when the device side is slow. The device side drains the buffers through a valid/take interface, and it always sees the words in the order they were fetched. A stop input marks the end of the order (a device end or a word-count rollover). After a stop, no new request is made until the next load. A fetch already under way still completes, and the buffered words can still be drained.

Top module: `wrfetch_pingpong`

## Requirements
- R1: After reset, `out_valid` is 0, `mem_addr` is 0 and `bank_out` is 0.
- R2: A cycle with `ld` high loads `ld_addr` into the active address and `ld_bank` into the bank; `bank_out` shows the new bank from the next cycle, and `ld` also clears a latched stop.
- R3: `rd_req` is high in exactly the cycles where `xfer_active` is 1, `stop` is 0, no stop is latched, no fetch is outstanding and at most one buffer holds an unconsumed word.
- R4: In a cycle with `rd_req` and `port_sel` both high, `mem_addr` equals the active address (otherwise it is 0), and the address then increments by one modulo 2^AW (0xFFFF is followed by 0x0000).
- R5: A `port_strb` while a fetch is outstanding captures `mem_data`; `out_valid` is 1 in every cycle in which at least one captured word is still unconsumed, and 0 otherwise.
- R6: No request is issued while both buffers hold data, or between the select and the strobe of a fetch (at most one fetch outstanding).
- R7: Words appear on `out_data` in fetch order; a cycle with `out_valid` and `out_take` both high consumes the head word, and the head word is held stable until it is consumed.
- R8: A cycle with `stop` high suppresses `rd_req` in that cycle and latches, so that no request follows until the next `ld`; a fetch already selected still completes, and buffered words are still delivered.
- R9: A capture and a consume in the same cycle both take effect, on different buffers.
- R10: `out_take` while `out_valid` is 0 is ignored: the order of later words is unchanged.
- R11: While `xfer_active` is 0, `rd_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld | input | 1 | Load address and bank, clear latched stop |
| ld_addr | input | AW | Start word address |
| ld_bank | input | BW | Bank number |
| xfer_active | input | 1 | Output transfer condition is set |
| stop | input | 1 | Order ends (device end or count rollover) |
| rd_req | output | 1 | Read request to port controller |
| bank_out | output | BW | Bank sent as target with the request |
| port_sel | input | 1 | Port select: address phase |
| mem_addr | output | AW | Word address, valid while selected |
| port_strb | input | 1 | Port strobe: data phase |
| mem_data | input | DW | Data word from memory |
| out_valid | output | 1 | Head buffer holds a word |
| out_data | output | DW | Head word |
| out_take | input | 1 | Device side consumes the head word |

## Verification
A memory strobe that fills one buffer can arrive in the same cycle as a device-side take that empties the other buffer. The bench provokes this case by sweeping the select and strobe latencies from 0 to 2 cycles against take periods of 1 to 3 cycles. In each cycle it compares `rd_req` with a prediction made from its own count of fetched and consumed words, and it checks that the coincident cases still yield every word once, in order. It also counts the cycles where both events fell together and requires that the sweep produced some.

// File: rtl/wrfetch_pingpong.sv
module wrfetch_pingpong #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic [BW-1:0] ld_bank,
  input  logic          xfer_active,
  input  logic          stop,
  output logic          rd_req,
  output logic [BW-1:0] bank_out,
  input  logic          port_sel,
  output logic [AW-1:0] mem_addr,
  input  logic          port_strb,
  input  logic [DW-1:0] mem_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_take
);

  logic [AW-1:0] addr_q;
  logic [BW-1:0] bank_q;
  logic [DW-1:0] buf_q [2];
  logic [1:0]    full_q;
  logic          wp_q, rp_q, pend_q, done_q;

  wire fetch_go = rd_req & port_sel;
  wire cap      = pend_q & port_strb;
  wire take     = out_take & full_q[rp_q];

  assign rd_req    = xfer_active & ~stop & ~done_q & ~pend_q & ~full_q[wp_q];
  assign bank_out  = bank_q;
  assign mem_addr  = fetch_go ? addr_q : '0;
  assign out_valid = full_q[rp_q];
  assign out_data  = buf_q[rp_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bank_q <= '0;
      full_q <= '0;
      wp_q   <= 1'b0;
      rp_q   <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ld) begin
        addr_q <= ld_addr;
        bank_q <= ld_bank;
      end else if (fetch_go) begin
        addr_q <= addr_q + 1'b1;
      end

      if (ld)        done_q <= 1'b0;
      else if (stop) done_q <= 1'b1;

      if (fetch_go) pend_q <= 1'b1;
      else if (cap) pend_q <= 1'b0;

      if (cap)  wp_q <= ~wp_q;
      if (take) rp_q <= ~rp_q;

      full_q <= (full_q | (cap ? (2'b01 << wp_q) : 2'b00))
                & ~(take ? (2'b01 << rp_q) : 2'b00);
    end
  end

  always_ff @(posedge clk) begin
    if (cap) buf_q[wp_q] <= mem_data;
  end

endmodule

// File: rtl/wrfetch_pingpong_chk.sv
module wrfetch_pingpong_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          port_sel,
  input logic          port_strb,
  input logic          stop,
  input logic          ld,
  input logic          xfer_active,
  input logic          out_valid,
  input logic          out_take,
  input logic [DW-1:0] out_data,
  input logic [AW-1:0] addr_q,
  input logic [1:0]    full_q,
  input logic          pend_q,
  input logic          done_q
);

  AST_REQ_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> xfer_active); // R11
  AST_NO_REQ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q == 2'b11) |-> !rd_req); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !rd_req); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && port_sel && !ld) |=> (addr_q == $past(addr_q) + 1'b1)); // R4
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_take) |=> (out_valid && $stable(out_data))); // R7
  AST_STOP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !ld) |=> (done_q && !rd_req)); // R8
  AST_CAPTURE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && port_strb) |=> out_valid); // R5

endmodule

bind wrfetch_pingpong wrfetch_pingpong_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .port_sel(port_sel),
  .port_strb(port_strb), .stop(stop), .ld(ld), .xfer_active(xfer_active),
  .out_valid(out_valid), .out_take(out_take), .out_data(out_data),
  .addr_q(addr_q), .full_q(full_q), .pend_q(pend_q), .done_q(done_q)
);

// File: tb/wrfetch_pingpong_bench.sv
module wrfetch_pingpong_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 16, BW = 4;
  localparam int NW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld = 1'b0, xfer_active = 1'b0, stop = 1'b0;
  logic port_sel = 1'b0, port_strb = 1'b0, out_take = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [BW-1:0] ld_bank = '0;
  logic [DW-1:0] mem_data = '0;
  logic rd_req, out_valid;
  logic [BW-1:0] bank_out;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] out_data;

  wrfetch_pingpong #(.AW(AW), .DW(DW), .BW(BW)) u_wrfetch_pingpong (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_addr(ld_addr), .ld_bank(ld_bank),
    .xfer_active(xfer_active), .stop(stop), .rd_req(rd_req), .bank_out(bank_out),
    .port_sel(port_sel), .mem_addr(mem_addr), .port_strb(port_strb),
    .mem_data(mem_data), .out_valid(out_valid), .out_data(out_data),
    .out_take(out_take)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0, nbad = 0, cyc = 0, coinc = 0;
  int nsel, nstrb, ncons, mstate, lat, sel_lat, strb_lat, period, tick;
  bit stop_sent, done_exp;
  logic [AW-1:0] start;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(1'b0, "watchdog", cyc, 150000);
        finish_run();
      end
    end
  end

  task automatic cycle();
    int occ;
    bit exp_req;
    occ = nstrb - ncons;
    stop = (nsel == NW) && !stop_sent;
    if (stop) stop_sent = 1'b1;
    exp_req = xfer_active && !stop && !done_exp && mstate == 0 && occ < 2;
    port_sel = 1'b0; port_strb = 1'b0; out_take = 1'b0;
    #1;
    check(rd_req == exp_req, "R3 rd_req", rd_req, exp_req);
    check(out_valid == (occ > 0), "R5 out_valid", out_valid, occ > 0);
    if (mstate == 0) begin
      if (rd_req) begin
        if (lat == sel_lat) begin port_sel = 1'b1; mstate = 1; lat = 0; end
        else lat++;
      end
    end else begin
      if (lat == strb_lat) begin
        port_strb = 1'b1;
        mem_data = word_of(start + AW'(nstrb));
        nstrb++;
        mstate = 0; lat = 0;
      end else lat++;
    end
    if (out_valid) begin
      if (tick % period == 0) begin
        out_take = 1'b1;
        check(out_data == word_of(start + AW'(ncons)), "R7 order", out_data,
              word_of(start + AW'(ncons)));
        ncons++;
      end
    end else if (tick % 2 == 1) begin
      out_take = 1'b1;  // R10: ignored take
    end
    tick++;
    #1;
    if (port_sel) begin
      check(mem_addr == start + AW'(nsel), "R4 mem_addr", mem_addr, start + AW'(nsel));
      nsel++;
    end else begin
      check(mem_addr == '0, "R4 idle addr", mem_addr, 0);
    end
    if (port_strb && out_take && out_valid) coinc++;
    if (stop) done_exp = 1'b1;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(mem_addr == '0, "R1 mem_addr", mem_addr, 0);
    check(bank_out == '0, "R1 bank_out", bank_out, 0);
    xfer_active = 1'b0;
    nsel = 0; nstrb = 0; ncons = 0; mstate = 0; lat = 0; tick = 1;
    sel_lat = 0; strb_lat = 0; period = 1; stop_sent = 1'b1; done_exp = 1'b0;
    start = '0;
    for (int k = 0; k < 4; k++) begin  // R11 and R10: no activity, takes ignored
      @(negedge clk);
      out_take = 1'b1;
      #1;
      check(rd_req == 1'b0, "R11 idle", rd_req, 0);
    end
    for (int cfg = 0; cfg < 27; cfg++) begin
      sel_lat = cfg % 3; strb_lat = (cfg / 3) % 3; period = cfg / 9 + 1;
      @(negedge clk);
      out_take = 1'b0; xfer_active = 1'b0; stop = 1'b0;
      ld = 1'b1; ld_addr = 16'hFFF8 + AW'(cfg); ld_bank = BW'(cfg);
      start = ld_addr;
      @(negedge clk);
      ld = 1'b0;
      #1;
      check(bank_out == BW'(cfg), "R2 bank", bank_out, cfg);
      nsel = 0; nstrb = 0; ncons = 0; mstate = 0; lat = 0; tick = 0;
      stop_sent = 1'b0; done_exp = 1'b0;
      xfer_active = 1'b1;
      n = 0;
      while (!(ncons == NW && mstate == 0) && n < 600) begin
        @(negedge clk);
        cycle();
        n++;
      end
      check(n < 600, "R7 drain", n, 600);
      check(nsel == NW, "R8 fetch count", nsel, NW);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        cycle();
      end
      check(nsel == NW && ncons == NW, "R8 after stop", nsel, NW);
      xfer_active = 1'b0;
    end
    check(coinc > 0, "R9 coincident capture/take", coinc, 1);
    finish_run();
  end
endmodule